// File: doc/BRIEF.md
# Mailbox Command Queue Sequencer

This block takes mailbox pointer writes from several processors sharing a system bus and runs the mailbox operations they name, one at a time. Every accepted write joins a single queue in arrival order. The processor that made the write gets an accept or a reject response in the same cycle. Each processor may have at most two operations outstanding, and the one currently running counts toward that limit.

To run the entry at the head of the queue, the block reads a four-word mailbox structure from memory into an internal buffer. It sends that structure as a command packet on the outbound link, with the packet-type code forced into the command field. It then waits for a status packet on the inbound link. The status overwrites the upper two buffered words, the merged structure is written back to memory, and the next entry may start. A status packet that arrives when none is awaited is discarded and raises a sticky error flag.

Top module: `mbox_seq`

## Requirements
- R1: Entries run in the order their writes were accepted, across all processors; the first fetch of an operation targets the address of the oldest unfinished accepted write.
- R2: A write with `wrValid` high gets `wrAck` in the same cycle if that processor has fewer than two unfinished operations, and `wrNack` otherwise. Only one of the two is ever high. A rejected write is discarded and never runs.
- R3: Only one operation runs at a time: no fetch and no packet word for an entry is issued until the previous entry's write-back has finished.
- R4: After the last packet word, memory writes for the operation begin only after a status packet has been taken. The processor's slot is freed at the cycle its fourth write-back word is accepted.
- R5: The fetch issues four reads (`memWe`=0) at byte addresses base+0, +8, +16, +24 in that order. Read data returns on `memRvalid` in request order.
- R6: The packet is four words in buffer order, with `pktLast` on the fourth. Word 0 has bits 13:12 replaced by binary 10. Every other bit of every word equals the fetched data.
- R7: The write-back issues four writes to base+0, +8, +16, +24. Words 0 and 1 carry the fetched values, word 2 carries `stsData[63:0]` and word 3 carries `stsData[127:64]`.
- R8: `stsValid` while no status is awaited (any time other than after the last packet word and before the status is taken) is dropped. It sets `errStale` on the next cycle, and `errStale` then stays high until reset.
- R9: During and right after reset, `memReq`, `pktValid`, `wrAck` and `errStale` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Mailbox pointer write strobe |
| wrCpu | input | CPU_W | Identifier of the writing processor |
| wrAddr | input | ADDR_W | Mailbox base byte address (32-byte aligned) |
| wrAck | output | 1 | Write accepted |
| wrNack | output | 1 | Write rejected |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 64 | Write data |
| memReady | input | 1 | Memory request accepted this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 64 | Read data |
| pktValid | output | 1 | Outbound packet word valid |
| pktReady | input | 1 | Outbound link takes the word |
| pktData | output | 64 | Outbound packet word |
| pktLast | output | 1 | Last word of packet |
| stsValid | input | 1 | Inbound status packet valid |
| stsData | input | 128 | Status words (word 2 low, word 3 high) |
| errStale | output | 1 | Sticky unexpected-status flag |

## Verification
The assertions check several things on every cycle. The per-processor counters never exceed two and always add up to the queue occupancy. A write-back never starts without a status in the previous cycle. A packet's first word carries the forced code. An out-of-turn status always sets the sticky flag, which never clears. First-come ordering across processors, rejected writes that never run, and the word-exact contents of packets and write-backs under stalling memory and link can only be shown by the bench's behavioural model. The same holds for a stray status that arrives mid-operation and must not trigger a write-back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W    = 64;
  localparam int NUM_WORDS = 4;
  localparam int CODE_LSB  = 12;
  localparam logic [1:0] CMD_CODE = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_WAIT,
    ST_WB
  } seqState_t;

  typedef struct packed {
    logic       capEn;
    logic [1:0] capIdx;
    logic       mergeEn;
    logic [1:0] selIdx;
  } dpCtl_t;
endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 32,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [CPU_W-1:0]  wrCpu,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              wrAck,
  output logic              wrNack,
  input  logic              popEn,
  output logic              headValid,
  output logic [ADDR_W-1:0] headAddr
);
  localparam int DEPTH = 2 * NUM_CPU;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CPU_W-1:0]  cpuMem  [DEPTH];
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [PTR_W-1:0]  wPtr, rPtr;
  logic [CNT_W-1:0]  count;
  logic [1:0]        pend [NUM_CPU];
  logic [CNT_W-1:0]  pendSum;
  logic              cpuOk, accept;
  logic [CPU_W-1:0]  headCpu;

  assign cpuOk     = ({1'b0, wrCpu} < (CPU_W + 1)'(NUM_CPU));
  assign accept    = wrValid && cpuOk && (pend[wrCpu] != 2'd2);
  assign wrAck     = accept;
  assign wrNack    = wrValid && !accept;
  assign headValid = (count != '0);
  assign headAddr  = addrMem[rPtr];
  assign headCpu   = cpuMem[rPtr];

  always_ff @(posedge clk) begin
    if (accept) begin
      cpuMem[wPtr]  <= wrCpu;
      addrMem[wPtr] <= wrAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else begin
      if (accept) wPtr <= (wPtr == PTR_W'(DEPTH - 1)) ? '0 : wPtr + 1'b1;
      if (popEn)  rPtr <= (rPtr == PTR_W'(DEPTH - 1)) ? '0 : rPtr + 1'b1;
      case ({accept, popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPU; c++) pend[c] <= 2'd0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        case ({accept && (wrCpu == CPU_W'(c)), popEn && (headCpu == CPU_W'(c))})
          2'b10:   pend[c] <= pend[c] + 2'd1;
          2'b01:   pend[c] <= pend[c] - 2'd1;
          default: pend[c] <= pend[c];
        endcase
      end
    end
  end

  always_comb begin
    pendSum = '0;
    for (int c = 0; c < NUM_CPU; c++) pendSum = pendSum + CNT_W'(pend[c]);
  end

  // R2: occupancy bounded by two entries per processor
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2: every queued entry belongs to exactly one processor's tally
  assert_pend_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    pendSum == count);

  // R3: completion only ever retires an existing entry
  assert_pop_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> headValid);

  generate
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_lim
      // R2: no processor exceeds two outstanding operations
      assert_pend_limit_R2: assert property (@(posedge clk) disable iff (!rstN)
        pend[g] <= 2'd2);
    end
  endgenerate
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic              memReady,
  input  logic              memRvalid,
  input  logic              stsValid,
  input  logic              pktReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pktValid,
  output logic              pktLast,
  output logic              popEn,
  output logic              errStale,
  output dpCtl_t            dpCtl
);
  seqState_t  state;
  logic [2:0] cnt, rxCnt;
  logic [4:0] wordOfs;

  assign wordOfs = {cnt[1:0], 3'b000};
  assign memAddr = headAddr + ADDR_W'(wordOfs);

  always_comb begin
    memReq         = 1'b0;
    memWe          = 1'b0;
    pktValid       = 1'b0;
    pktLast        = 1'b0;
    popEn          = 1'b0;
    dpCtl.capEn    = 1'b0;
    dpCtl.capIdx   = rxCnt[1:0];
    dpCtl.mergeEn  = 1'b0;
    dpCtl.selIdx   = cnt[1:0];
    case (state)
      ST_FETCH: begin
        memReq      = (cnt != 3'd4);
        dpCtl.capEn = memRvalid;
      end
      ST_SEND: begin
        pktValid = 1'b1;
        pktLast  = (cnt == 3'd3);
      end
      ST_WAIT: dpCtl.mergeEn = stsValid;
      ST_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        popEn  = memReady && (cnt == 3'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rxCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (headValid) begin
          state <= ST_FETCH;
          cnt   <= '0;
          rxCnt <= '0;
        end
        ST_FETCH: begin
          if (memReq && memReady) cnt <= cnt + 3'd1;
          if (memRvalid) begin
            rxCnt <= rxCnt + 3'd1;
            if (rxCnt == 3'd3) begin
              state <= ST_SEND;
              cnt   <= '0;
            end
          end
        end
        ST_SEND: if (pktReady) begin
          if (cnt == 3'd3) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end else cnt <= cnt + 3'd1;
        end
        ST_WAIT: if (stsValid) begin
          state <= ST_WB;
          cnt   <= '0;
        end
        ST_WB: if (memReady) begin
          if (cnt == 3'd3) state <= ST_IDLE;
          else cnt <= cnt + 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errStale <= 1'b0;
    else if (stsValid && state != ST_WAIT) errStale <= 1'b1;
  end

  // R8: an unexpected status always raises the flag
  assert_stale_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stsValid && state != ST_WAIT) |=> errStale);

  // R8: the flag is sticky
  assert_stale_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errStale |=> errStale);

  // R4: write-back begins only right after a status was taken
  assert_wb_after_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(stsValid));

  // R3: packet and memory traffic never overlap
  assert_serial_R3: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> !memReq);
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
(
  input  logic                clk,
  input  dpCtl_t              dpCtl,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic [2*WORD_W-1:0] stsData,
  output logic [WORD_W-1:0]   pktData,
  output logic [WORD_W-1:0]   memWdata
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [WORD_W-1:0] selWord;

  always_ff @(posedge clk) begin
    if (dpCtl.capEn) words[dpCtl.capIdx] <= memRdata;
    if (dpCtl.mergeEn) begin
      words[2] <= stsData[WORD_W-1:0];
      words[3] <= stsData[2*WORD_W-1:WORD_W];
    end
  end

  assign selWord  = words[dpCtl.selIdx];
  assign memWdata = selWord;

  always_comb begin
    pktData = selWord;
    if (dpCtl.selIdx == 2'd0) pktData[CODE_LSB+1:CODE_LSB] = CMD_CODE;
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 32,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [CPU_W-1:0]  wrCpu,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              wrAck,
  output logic              wrNack,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic              memReady,
  input  logic              memRvalid,
  input  logic [63:0]       memRdata,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [63:0]       pktData,
  output logic              pktLast,
  input  logic              stsValid,
  input  logic [127:0]      stsData,
  output logic              errStale
);
  logic              popEn, headValid;
  logic [ADDR_W-1:0] headAddr;
  dpCtl_t            dpCtl;

  mbox_queue #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_queue (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrCpu(wrCpu), .wrAddr(wrAddr),
    .wrAck(wrAck), .wrNack(wrNack), .popEn(popEn),
    .headValid(headValid), .headAddr(headAddr)
  );

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headAddr(headAddr),
    .memReady(memReady), .memRvalid(memRvalid), .stsValid(stsValid),
    .pktReady(pktReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .pktValid(pktValid), .pktLast(pktLast), .popEn(popEn),
    .errStale(errStale), .dpCtl(dpCtl)
  );

  mbox_dp u_dp (
    .clk(clk), .dpCtl(dpCtl), .memRdata(memRdata), .stsData(stsData),
    .pktData(pktData), .memWdata(memWdata)
  );

  // R6: the first packet word always carries the forced command code
  assert_code_forced_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && dpCtl.selIdx == 2'd0) |-> (pktData[13:12] == 2'b10));
endmodule

// File: tb/sim_mbox_seq.sv
module sim_mbox_seq;
  localparam int NUM_CPU = 4;
  localparam int ADDR_W  = 32;
  localparam int CPU_W   = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrValid, wrAck, wrNack, memReq, memWe, memReady, memRvalid;
  logic pktValid, pktReady, pktLast, stsValid, errStale;
  logic [CPU_W-1:0]  wrCpu;
  logic [ADDR_W-1:0] wrAddr, memAddr;
  logic [63:0]       memWdata, memRdata, pktData;
  logic [127:0]      stsData;

  mbox_seq #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrCpu(wrCpu), .wrAddr(wrAddr),
    .wrAck(wrAck), .wrNack(wrNack), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRvalid(memRvalid), .memRdata(memRdata), .pktValid(pktValid),
    .pktReady(pktReady), .pktData(pktData), .pktLast(pktLast),
    .stsValid(stsValid), .stsData(stsData), .errStale(errStale)
  );

  typedef struct { int cpu; longint unsigned addr; } ent_t;
  ent_t mq[$];
  longint unsigned rdQ[$];
  logic [63:0] mem [longint unsigned];
  int pend [NUM_CPU];
  int vectors = 0, miscompares = 0;
  int rdk = 0, pk = 0, wk = 0;
  bit waiting = 0, stsGiven = 0, expErr = 0, stale;
  logic [63:0] stsW2, stsW3;

  function automatic logic [63:0] memGet(longint unsigned a);
    if (mem.exists(a)) return mem[a];
    return {a[31:0] ^ 32'hC3A5_5A3C, a[31:0] + 32'h0001_3F01};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    rstN = 0; wrValid = 0; wrCpu = 0; wrAddr = 0; memReady = 0; memRvalid = 0;
    memRdata = 0; pktReady = 0; stsValid = 0; stsData = 0;
    for (int c = 0; c < NUM_CPU; c++) pend[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(memReq == 0, "R9", "memReq in reset", 64'(memReq), 0);
    check(pktValid == 0, "R9", "pktValid in reset", 64'(pktValid), 0);
    check(errStale == 0, "R9", "errStale in reset", 64'(errStale), 0);
    rstN = 1;
    #1;
    check(wrAck == 0, "R9", "wrAck after reset", 64'(wrAck), 0);

    for (int cyc = 0; ; cyc++) begin
      @(negedge clk);
      check(errStale == expErr, "R8", "errStale", 64'(errStale), 64'(expErr));
      if (cyc >= 20000) begin
        check(0, "R3", "watchdog expired, queue left", 64'(mq.size()), 0);
        break;
      end
      if (cyc >= 3000 && mq.size() == 0 && rdQ.size() == 0) break;

      // stimulus
      wrValid = 0; stsValid = 0; memRvalid = 0; stale = 0;
      if (cyc >= 10 && cyc <= 12) begin
        wrValid = 1; wrCpu = 2'd1; wrAddr = 32'h0000_1000 + 32'(cyc * 32);
      end else if (cyc >= 20 && cyc < 3000 && $urandom % 100 < 25) begin
        wrValid = 1; wrCpu = CPU_W'($urandom % NUM_CPU);
        wrAddr = $urandom & 32'h0000_FFE0;
      end
      if (waiting && $urandom % 4 == 0) begin
        stsW2 = {$urandom, $urandom}; stsW3 = {$urandom, $urandom};
        stsData = {stsW3, stsW2}; stsValid = 1; waiting = 0; stsGiven = 1;
      end else if (!waiting && (cyc == 5 || (cyc >= 20 && $urandom % 100 < 2))) begin
        stsData = {$urandom, $urandom, $urandom, $urandom}; stsValid = 1; stale = 1;
      end
      memReady = ($urandom % 4 != 0);
      pktReady = ($urandom % 3 != 0);
      if (rdQ.size() > 0 && $urandom % 4 != 0) begin
        memRvalid = 1; memRdata = memGet(rdQ.pop_front());
      end
      #1;

      // R2: accept/reject decision
      begin
        bit expAck;
        expAck = wrValid && pend[wrCpu] < 2;
        check(wrAck == expAck, "R2", "wrAck", 64'(wrAck), 64'(expAck));
        check(wrNack == (wrValid && !expAck), "R2", "wrNack", 64'(wrNack), 64'(wrValid && !expAck));
        if (expAck) begin
          mq.push_back('{cpu: int'(wrCpu), addr: longint'(wrAddr)});
          pend[wrCpu]++;
        end
      end

      if (memReq && memReady) begin
        if (!memWe) begin
          if (mq.size() == 0 || rdk >= 4)
            check(0, "R3", "read outside a fetch", 64'(memAddr), 0);
          else begin
            check(memAddr == 32'(mq[0].addr + 8 * rdk), (rdk == 0) ? "R1" : "R5",
                  "read address", 64'(memAddr), 64'(mq[0].addr + 8 * rdk));
            rdQ.push_back(longint'(memAddr));
            rdk++;
          end
        end else begin
          if (!stsGiven || mq.size() == 0)
            check(0, "R4", "write before status", 64'(memAddr), 0);
          else begin
            logic [63:0] expD;
            longint unsigned a;
            a = mq[0].addr + 8 * wk;
            expD = (wk == 0 || wk == 1) ? memGet(a) : ((wk == 2) ? stsW2 : stsW3);
            check(memAddr == 32'(a), "R7", "write address", 64'(memAddr), a);
            check(memWdata == expD, "R7", "write data", memWdata, expD);
            wk++;
            if (wk == 4) begin
              mem[mq[0].addr + 16] = stsW2;
              mem[mq[0].addr + 24] = stsW3;
              pend[mq[0].cpu]--;
              void'(mq.pop_front());
              rdk = 0; pk = 0; wk = 0; stsGiven = 0;
            end
          end
        end
      end

      if (pktValid && pktReady) begin
        if (mq.size() == 0 || rdk < 4 || pk >= 4)
          check(0, "R3", "packet word outside a send", pktData, 0);
        else begin
          logic [63:0] expP;
          expP = memGet(mq[0].addr + 8 * pk);
          if (pk == 0) expP[13:12] = 2'b10;
          check(pktData == expP, "R6", "packet word", pktData, expP);
          check(pktLast == (pk == 3), "R6", "pktLast", 64'(pktLast), 64'(pk == 3));
          pk++;
          if (pk == 4) waiting = 1;
        end
      end

      if (stale) expErr = 1;  // R8 flag expected from the next cycle on
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule